// File: doc/BRIEF.md
# Segmented address translation unit

This block turns a 23-bit CPU word address into a 22-bit backplane word address. It sits between a 16-bit-data processor and a word-addressed system bus. The top bit of the CPU word address chooses the path. When that bit is 1, one of four segment registers supplies a 12-bit base field. When it is 0, a fixed bypass base is used instead. The base field is scaled by 512 words and added to the CPU address. The top bit of the result is then duplicated into the most significant output bit.

Software loads the segment registers through a small write port, using eight word offsets and two offsets per register. A separate boot flag picks which of the two bypass bases applies. The reset input sets the flag. Software can later clear or set it again through an init-register write, so that code which starts out remapped into the high bus region can later run on the plain mapping.

Top module: `seg_xlate`

## Requirements
- R1: After reset all four segment registers hold zero, so a segmented access (cpu_addr[22]=1) passes bits 20:0 through unchanged, and the boot flag is set.
- R2: When cpu_addr[22] is 1, the register selected by cpu_addr[21:20] supplies the base field, which is register bits 11:0.
- R3: A reg_wr with an odd reg_off loads reg_data[15:0] into bits 15:0 of register reg_off[2:1]. Register bits 23:16 are left unchanged.
- R4: A reg_wr with an even reg_off loads reg_data[7:0] into bits 23:16 of register reg_off[2:1]. The base field is left unchanged, so translation does not change.
- R5: A write changes only the register chosen by reg_off[2:1]. The other three registers keep their values.
- R6: When cpu_addr[22] is 0, the base field is 12'hE00 (base 24'hFFFE00) while the boot flag is set, and 12'h000 (base 24'hFFF000) while it is clear.
- R7: An init_wr loads the boot flag from init_data[0]. Bits 15:1 of init_data have no effect.
- R8: Asserting rst sets the boot flag and clears the segment registers, whatever state they held before. rst takes priority over a write strobe in the same cycle.
- R9: bus_addr[20:0] = (cpu_addr[20:0] + base_field*512) mod 2^21, and bus_addr[21] equals bus_addr[20].
- R10: bus_addr is combinational in cpu_addr. A register or init write changes it only after the clock edge that samples the strobe, and it is otherwise stable while cpu_addr is stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; sets the boot flag and clears the segment registers |
| cpu_addr | input | 23 | CPU word address |
| reg_wr | input | 1 | Segment register write strobe |
| reg_off | input | 3 | Segment register word offset |
| reg_data | input | 16 | Segment register write data |
| init_wr | input | 1 | Boot flag write strobe |
| init_data | input | 16 | Boot flag write data (bit 0 used) |
| bus_addr | output | 22 | Translated bus word address |

## Verification
Each segment register is loaded with several base fields. These include 12'h000, 12'hFFF and bit patterns that differ from one register to the next, and addresses are swept across all four selectors for each loading. A wrong selector or crosstalk between registers therefore shows up as a mismatched offset. The sweep includes addresses near the top of the 21-bit range, which separate a true modular add with bit-20 duplication from a wider or truncated sum. Bypass addresses are checked with the boot flag in both states, including an init word whose upper bits are all ones. Writes to the upper byte are checked to leave translation untouched, and the output is sampled before the write edge to show when a write takes effect.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned XL_SEG_W   = 24;
  localparam int unsigned XL_FIELD_W = 12;
  localparam int unsigned XL_SHIFT   = 9;
  localparam logic [XL_SEG_W-1:0] XL_BOOT_BASE = 24'hFFFE00;
  localparam logic [XL_SEG_W-1:0] XL_RUN_BASE  = 24'hFFF000;
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int unsigned NUM_SEG = 4,
  parameter int unsigned SEG_W   = 24,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned OFF_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr,
  input  logic [OFF_W-1:0]                off,
  input  logic [DATA_W-1:0]               data,
  output logic [NUM_SEG-1:0][SEG_W-1:0]   segs
);
  localparam int unsigned HI_W = SEG_W - DATA_W;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic hit;
    assign hit = wr && (off[OFF_W-1:1] == (OFF_W-1)'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        segs[g] <= '0;
      end else if (hit) begin
        if (off[0]) segs[g][DATA_W-1:0]     <= data;
        else        segs[g][SEG_W-1:DATA_W] <= data[HI_W-1:0];
      end
    end
  end
endmodule

// File: rtl/seg_boot_flag.sv
module seg_boot_flag #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_wr,
  input  logic [DATA_W-1:0] init_data,
  output logic              boot
);
  always_ff @(posedge clk) begin
    if (rst)          boot <= 1'b1;
    else if (init_wr) boot <= init_data[0];
  end
endmodule

// File: rtl/seg_calc.sv
module seg_calc #(
  parameter int unsigned NUM_SEG = 4,
  parameter int unsigned SEG_W   = 24,
  parameter int unsigned FIELD_W = 12,
  parameter int unsigned SHIFT   = 9,
  parameter int unsigned CPU_AW  = 23,
  parameter int unsigned BUS_AW  = 22,
  parameter logic [SEG_W-1:0] BOOT_BASE = 24'hFFFE00,
  parameter logic [SEG_W-1:0] RUN_BASE  = 24'hFFF000
) (
  input  logic [CPU_AW-1:0]             cpu_addr,
  input  logic [NUM_SEG-1:0][SEG_W-1:0] segs,
  input  logic                          boot,
  output logic [BUS_AW-1:0]             bus_addr
);
  localparam int unsigned SEL_W  = $clog2(NUM_SEG);
  localparam int unsigned KEEP_W = BUS_AW - 1;

  logic [SEL_W-1:0]   sel;
  logic [FIELD_W-1:0] base;
  logic [KEEP_W-1:0]  offs;
  logic [KEEP_W-1:0]  sum;

  assign sel = cpu_addr[CPU_AW-2 -: SEL_W];

  always_comb begin
    if (cpu_addr[CPU_AW-1]) base = segs[sel][FIELD_W-1:0];
    else if (boot)          base = BOOT_BASE[FIELD_W-1:0];
    else                    base = RUN_BASE[FIELD_W-1:0];
  end

  assign offs     = KEEP_W'({base, {SHIFT{1'b0}}});
  assign sum      = cpu_addr[KEEP_W-1:0] + offs;
  assign bus_addr = {sum[KEEP_W-1], sum};
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned NUM_SEG = 4,
  parameter int unsigned CPU_AW  = 23,
  parameter int unsigned BUS_AW  = 22,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned OFF_W   = $clog2(NUM_SEG) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              reg_wr,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [DATA_W-1:0] reg_data,
  input  logic              init_wr,
  input  logic [DATA_W-1:0] init_data,
  output logic [BUS_AW-1:0] bus_addr
);
  logic [NUM_SEG-1:0][XL_SEG_W-1:0] segs;
  logic                             boot;

  seg_bank #(
    .NUM_SEG(NUM_SEG), .SEG_W(XL_SEG_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
  ) bank_i (
    .clk(clk), .rst(rst), .wr(reg_wr), .off(reg_off), .data(reg_data), .segs(segs)
  );

  seg_boot_flag #(.DATA_W(DATA_W)) flag_i (
    .clk(clk), .rst(rst), .init_wr(init_wr), .init_data(init_data), .boot(boot)
  );

  seg_calc #(
    .NUM_SEG(NUM_SEG), .SEG_W(XL_SEG_W), .FIELD_W(XL_FIELD_W), .SHIFT(XL_SHIFT),
    .CPU_AW(CPU_AW), .BUS_AW(BUS_AW),
    .BOOT_BASE(XL_BOOT_BASE), .RUN_BASE(XL_RUN_BASE)
  ) calc_i (
    .cpu_addr(cpu_addr), .segs(segs), .boot(boot), .bus_addr(bus_addr)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_xlate_pkg::*;
#(
  parameter int unsigned CPU_AW = 23,
  parameter int unsigned BUS_AW = 22,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFF_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              reg_wr,
  input logic [OFF_W-1:0]  reg_off,
  input logic [DATA_W-1:0] reg_data,
  input logic              init_wr,
  input logic [DATA_W-1:0] init_data,
  input logic [BUS_AW-1:0] bus_addr
);
  localparam int unsigned KEEP_W = BUS_AW - 1;
  localparam logic [KEEP_W-1:0] BOOT_OFS = KEEP_W'({XL_BOOT_BASE[XL_FIELD_W-1:0], {XL_SHIFT{1'b0}}});
  localparam logic [KEEP_W-1:0] RUN_OFS  = KEEP_W'({XL_RUN_BASE[XL_FIELD_W-1:0], {XL_SHIFT{1'b0}}});

  // R9: top output bit mirrors the next one down
  a_r9_top_copy: assert property (@(posedge clk) disable iff (rst)
    bus_addr[BUS_AW-1] == bus_addr[BUS_AW-2]);

  // R6, R8: right after reset the bypass path uses the boot base
  a_r8_boot_bypass: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !cpu_addr[CPU_AW-1]) |->
      bus_addr[KEEP_W-1:0] == KEEP_W'(cpu_addr[KEEP_W-1:0] + BOOT_OFS));

  // R7: clearing the flag selects the run base for bypass accesses
  a_r7_init_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(init_wr && !init_data[0] && !rst) && !cpu_addr[CPU_AW-1]) |->
      bus_addr[KEEP_W-1:0] == KEEP_W'(cpu_addr[KEEP_W-1:0] + RUN_OFS));

  // R3: a low-half write sets the base field of the addressed segment
  a_r3_low_load: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_wr && reg_off[0] && !rst) && cpu_addr[CPU_AW-1] &&
     cpu_addr[CPU_AW-2 -: OFF_W-1] == $past(reg_off[OFF_W-1:1])) |->
      bus_addr[KEEP_W-1:0] ==
        KEEP_W'(cpu_addr[KEEP_W-1:0] + KEEP_W'({$past(reg_data[XL_FIELD_W-1:0]), {XL_SHIFT{1'b0}}})));

  // R4: an upper-byte write never moves a segmented translation
  a_r4_high_inert: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_wr && !reg_off[0] && !init_wr && !rst) && $stable(cpu_addr) && cpu_addr[CPU_AW-1]) |->
      $stable(bus_addr));

  // R10: with no write or reset, a steady address gives a steady output
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(reg_wr) && !$past(init_wr) && !$past(rst) && $stable(cpu_addr)) |->
      $stable(bus_addr));
endmodule

bind seg_xlate seg_xlate_chk #(
  .CPU_AW(CPU_AW), .BUS_AW(BUS_AW), .DATA_W(DATA_W), .OFF_W(OFF_W)
) chk_i (.*);

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [22:0] cpu_addr = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_off = '0;
  logic [15:0] reg_data = '0;
  logic        init_wr = 1'b0;
  logic [15:0] init_data = '0;
  logic [21:0] bus_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] mreg [4];
  logic        mflag;

  always #4 clk = ~clk;

  seg_xlate dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_data(reg_data), .init_wr(init_wr), .init_data(init_data), .bus_addr(bus_addr)
  );

  function automatic logic [21:0] expect_of(input logic [22:0] a);
    logic [11:0] b;
    logic [20:0] s;
    if (a[22]) b = mreg[a[21:20]][11:0];
    else       b = mflag ? 12'hE00 : 12'h000;
    s = a[20:0] + {b, 9'b0};
    return {s[20], s};
  endfunction

  task automatic check_at(input logic [22:0] a, input string tag);
    logic [21:0] e;
    cpu_addr = a;
    #1;
    e = expect_of(a);
    checks++;
    if (bus_addr !== e) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_addr, e);
    end
  endtask

  task automatic reg_write(input logic [2:0] off, input logic [15:0] d, input logic [22:0] probe);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_data = d;
    check_at(probe, "R10 before edge");
    @(negedge clk);
    reg_wr = 1'b0;
    if (off[0]) mreg[off[2:1]][15:0]  = d;
    else        mreg[off[2:1]][23:16] = d[7:0];
  endtask

  task automatic init_write(input logic [15:0] d);
    @(negedge clk);
    init_wr = 1'b1; init_data = d;
    check_at(23'h012345, "R10 before init edge");
    @(negedge clk);
    init_wr = 1'b0;
    mflag = d[0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    reg_wr = 1'b1; reg_off = 3'd1; reg_data = 16'h0ABC;
    init_wr = 1'b1; init_data = 16'h0000;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; reg_wr = 1'b0; init_wr = 1'b0;
    for (int k = 0; k < 4; k++) mreg[k] = '0;
    mflag = 1'b1;
  endtask

  task automatic bypass_sweep(input string tag);
    for (int i = 0; i < 8; i++)
      check_at({1'b0, 22'(i * 22'h07D3B1 + 22'h15)}, tag);
    check_at(23'h03FFFF, tag);
    check_at(23'h1FFFFF, tag);
  endtask

  task automatic seg_sweep(input string tag);
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 6; i++)
        check_at({1'b1, 2'(k), 20'(i * 20'h2B9C7 + 20'h3)}, tag);
      check_at({1'b1, 2'(k), 20'hFFFFF}, tag);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) mreg[k] = '0;
    mflag = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 R6: reset state, boot base on bypass, zero segments
    bypass_sweep("R1 R6 boot bypass");
    seg_sweep("R1 zero segments");

    // R7: flag clear with upper bits set, then set, then clear
    init_write(16'hFFFE);
    bypass_sweep("R7 R6 run bypass");
    init_write(16'h0001);
    bypass_sweep("R7 flag set");
    init_write(16'h7FF0);
    bypass_sweep("R7 flag clear again");

    // R2 R3 R5 R9: several base patterns per segment
    for (int r = 0; r < 5; r++) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] d;
        d = (r == 4) ? 16'hFFFF : 16'((k * 16'h5A5 + r * 16'h3A7 + 16'hF000) & 16'hFFFF);
        reg_write({2'(k), 1'b1}, d, {1'b1, 2'(k), 20'h0F0F0});
      end
      seg_sweep("R2 R3 R5 R9 segment");
    end

    // R4: upper-byte writes leave translation alone
    for (int k = 0; k < 4; k++)
      reg_write({2'(k), 1'b0}, 16'hA5FF - 16'(k), {1'b1, 2'(k), 20'h00001});
    seg_sweep("R4 upper byte inert");

    // R5: one register rewritten, others unchanged
    reg_write(3'd5, 16'h0123, 23'h500000);
    seg_sweep("R5 isolation");
    bypass_sweep("R7 flag kept over reg writes");

    // R8: reset from dirty state, with writes in the same cycle
    do_reset();
    bypass_sweep("R8 reset boot bypass");
    seg_sweep("R8 reset clears segments");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule